// File: doc/BRIEF.md
# Single-Step Script Execution Controller

This block decides when a script-instruction sequencer may run. Software starts it with a one-cycle start strobe. The sequencer executes instructions and reports each finished one with a completion pulse. In free-running mode the controller keeps the sequencer enabled until some interrupt source fires. In single-step mode it halts after every completed instruction and latches a dedicated step interrupt, so software can inspect state between instructions.

All interrupt causes are kept as sticky status bits: one for the step event and one per external source. A read of the status register clears every latched bit. A start strobe is honoured only while no status bit is pending, so the restart sequence is always a status read followed by a fresh start. The interrupt request is the masked OR of the latched bits.

The step-mode input is sampled only at instruction boundaries: when a start is accepted and at each completion. A change made mid-instruction therefore governs the following instruction, not the current one.

Top module: `step_exec_ctrl`

## Requirements
- R1: After reset, `run_o`, `step_irq_o`, `src_pend_o` and `irq_o` are all zero.
- R2: A start strobe is accepted when the block is not running, no status bit is latched and no source pulse arrives in the same cycle. `run_o` is then high from the next cycle.
- R3: While running with step mode in effect, a completion pulse makes `run_o` low and `step_irq_o` high in the next cycle.
- R4: While running with step mode not in effect, completion pulses leave `run_o` high and `step_irq_o` low.
- R5: A pulse on bit k of `irq_src_i` while running makes `run_o` low in the next cycle and sets bit k of `src_pend_o`.
- R6: A step event and a source pulse in the same cycle latch both `step_irq_o` and the source's bit of `src_pend_o`.
- R7: A cycle with `stat_rd_i` high clears all latched status bits in the next cycle. A source pulse or step event in that same cycle is kept set.
- R8: A start strobe while any status bit is latched is ignored and the block stays halted. A start strobe while running has no effect.
- R9: `irq_o` is high exactly when some latched bit has its mask bit at 1. `step_mask_i` gates `step_irq_o`, and bit k of `src_mask_i` gates bit k of `src_pend_o`.
- R10: `step_mode_i` is sampled when a start is accepted and at each completion pulse. The sampled value decides whether the following completion halts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start strobe from software |
| step_mode_i | input | 1 | Single-step mode control |
| instr_done_i | input | 1 | Instruction-complete pulse from the execution engine |
| irq_src_i | input | NUM_SRC | Pulses from other interrupt sources |
| stat_rd_i | input | 1 | Status-register read strobe, clears latched bits |
| step_mask_i | input | 1 | Enable of the step bit into the request |
| src_mask_i | input | NUM_SRC | Per-source enables into the request |
| run_o | output | 1 | Run enable to the sequencer |
| step_irq_o | output | 1 | Latched step interrupt |
| src_pend_o | output | NUM_SRC | Latched source interrupts |
| irq_o | output | 1 | Combined masked interrupt request |

## Verification
The bound checker watches on every cycle the following behaviours:
- a step event or a source pulse halts the sequencer;
- a start is refused while status is pending, and an eligible start is accepted;
- a quiet read empties the status;
- a raised request is always backed by a latched bit.

Only the directed scenarios can show some other behaviours:
- how the boundary sampling of step mode plays out over several instructions, in both directions;
- that a read and a new event in the same cycle keep the new event;
- the full restart sequence;
- the effect of individual mask bits.

// File: rtl/sec_pkg.sv
// Package: shared types of the single-step execution controller.
package sec_pkg;
    // Sequencer control state.
    typedef enum logic [1:0] {
        SEC_IDLE = 2'd0,
        SEC_RUN  = 2'd1,
        SEC_HALT = 2'd2
    } sec_state_e;
endpackage

// File: rtl/sec_run_fsm.sv
// Run/halt sequencer control.
// Accepts a start only when nothing is pending. While running, halts on a
// step event or any source pulse. Samples step mode at instruction boundaries.
// Assumes start_i and instr_done_i are single-cycle pulses.
module sec_run_fsm
    import sec_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic step_mode_i,
    input  logic instr_done_i,
    input  logic src_evt_i,
    input  logic pend_any_i,
    output logic run_o,
    output logic step_evt_o,
    output logic step_eff_o
);
    sec_state_e state_q, state_d;
    logic       step_eff_q;
    logic       accept;
    logic       running;

    assign running    = (state_q == SEC_RUN);
    assign accept     = !running && start_i && !pend_any_i && !src_evt_i;
    assign step_evt_o = running && instr_done_i && step_eff_q;
    assign run_o      = running;
    assign step_eff_o = step_eff_q;

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        if (accept) begin
            state_d = SEC_RUN;
        end else if (running && (step_evt_o || src_evt_i)) begin
            state_d = SEC_HALT;
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEC_IDLE;
        else        state_q <= state_d;
    end

    // Step-mode sample taken at each instruction boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_eff_q <= 1'b0;
        end else if (accept || (running && instr_done_i)) begin
            step_eff_q <= step_mode_i;
        end
    end
endmodule

// File: rtl/sec_status.sv
// Sticky interrupt status bits with clear-on-read.
// A set in the same cycle as a read wins, so no event is lost.
module sec_status #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic         clr_i,
    output logic [W-1:0] stat_o
);
    logic [W-1:0] stat_q;

    for (genvar i = 0; i < W; i++) begin : g_bit
        // One sticky bit: set dominates clear.
        always_ff @(posedge clk) begin
            if (!rst_n) stat_q[i] <= 1'b0;
            else        stat_q[i] <= set_i[i] | (stat_q[i] & ~clr_i);
        end
    end

    assign stat_o = stat_q;
endmodule

// File: rtl/sec_irq_merge.sv
// Masked OR of latched status bits into one request.
module sec_irq_merge #(
    parameter int W = 5
) (
    input  logic [W-1:0] stat_i,
    input  logic [W-1:0] mask_i,
    output logic         irq_o
);
    assign irq_o = |(stat_i & mask_i);
endmodule

// File: rtl/step_exec_ctrl.sv
// Top: single-step script execution controller.
// Status bit 0 is the step event; bits 1..NUM_SRC are the external sources.
// Assumes all inputs are synchronous to clk.
module step_exec_ctrl #(
    parameter int NUM_SRC = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               step_mode_i,
    input  logic               instr_done_i,
    input  logic [NUM_SRC-1:0] irq_src_i,
    input  logic               stat_rd_i,
    input  logic               step_mask_i,
    input  logic [NUM_SRC-1:0] src_mask_i,
    output logic               run_o,
    output logic               step_irq_o,
    output logic [NUM_SRC-1:0] src_pend_o,
    output logic               irq_o
);
    localparam int W = NUM_SRC + 1;

    logic         step_evt;
    logic         step_eff;
    logic [W-1:0] stat;

    sec_run_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .step_mode_i  (step_mode_i),
        .instr_done_i (instr_done_i),
        .src_evt_i    (|irq_src_i),
        .pend_any_i   (|stat),
        .run_o        (run_o),
        .step_evt_o   (step_evt),
        .step_eff_o   (step_eff)
    );

    sec_status #(.W(W)) u_stat (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  ({irq_src_i, step_evt}),
        .clr_i  (stat_rd_i),
        .stat_o (stat)
    );

    sec_irq_merge #(.W(W)) u_irq (
        .stat_i (stat),
        .mask_i ({src_mask_i, step_mask_i}),
        .irq_o  (irq_o)
    );

    assign step_irq_o = stat[0];
    assign src_pend_o = stat[W-1:1];
endmodule

// File: rtl/step_exec_ctrl_chk.sv
// Checker for step_exec_ctrl, attached by bind below.
module step_exec_ctrl_chk #(
    parameter int NUM_SRC = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start_i,
    input logic               instr_done_i,
    input logic [NUM_SRC-1:0] irq_src_i,
    input logic               stat_rd_i,
    input logic               run_o,
    input logic               step_irq_o,
    input logic [NUM_SRC-1:0] src_pend_o,
    input logic               irq_o,
    input logic               step_eff
);
    assert_step_halts_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run_o && instr_done_i && step_eff) |=> (!run_o && step_irq_o));

    assert_src_halts_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (run_o && (|irq_src_i)) |=> (!run_o && ((src_pend_o & $past(irq_src_i)) == $past(irq_src_i))));

    assert_quiet_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd_i && !run_o && (irq_src_i == '0)) |=> (!step_irq_o && (src_pend_o == '0)));

    assert_no_restart_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_o && (step_irq_o || (|src_pend_o))) |=> !run_o);

    assert_start_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !run_o && !step_irq_o && (src_pend_o == '0) && (irq_src_i == '0)) |=> run_o);

    assert_irq_backed_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (step_irq_o || (|src_pend_o)));
endmodule

bind step_exec_ctrl step_exec_ctrl_chk #(.NUM_SRC(NUM_SRC)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .instr_done_i (instr_done_i),
    .irq_src_i    (irq_src_i),
    .stat_rd_i    (stat_rd_i),
    .run_o        (run_o),
    .step_irq_o   (step_irq_o),
    .src_pend_o   (src_pend_o),
    .irq_o        (irq_o),
    .step_eff     (step_eff)
);

// File: tb/step_exec_ctrl_tb.sv
// Directed bench for step_exec_ctrl: one task per scenario.
module step_exec_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          step_mode_i = 1'b0;
    logic          instr_done_i = 1'b0;
    logic [NS-1:0] irq_src_i = '0;
    logic          stat_rd_i = 1'b0;
    logic          step_mask_i = 1'b1;
    logic [NS-1:0] src_mask_i = '1;
    logic          run_o, step_irq_o, irq_o;
    logic [NS-1:0] src_pend_o;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    step_exec_ctrl #(.NUM_SRC(NS)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .step_mode_i(step_mode_i),
        .instr_done_i(instr_done_i), .irq_src_i(irq_src_i), .stat_rd_i(stat_rd_i),
        .step_mask_i(step_mask_i), .src_mask_i(src_mask_i), .run_o(run_o),
        .step_irq_o(step_irq_o), .src_pend_o(src_pend_o), .irq_o(irq_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic pulse_start();
        start_i = 1'b1; tick(); start_i = 1'b0;
    endtask

    task automatic pulse_done();
        instr_done_i = 1'b1; tick(); instr_done_i = 1'b0;
    endtask

    task automatic do_read();
        stat_rd_i = 1'b1; tick(); stat_rd_i = 1'b0;
    endtask

    // Halt if running, then empty the status.
    task automatic settle();
        if (run_o) begin
            irq_src_i = 4'b0001; tick(); irq_src_i = '0;
        end
        do_read();
    endtask

    task automatic t_reset();
        check("R1 run", run_o, 0);
        check("R1 step_irq", step_irq_o, 0);
        check("R1 pend", src_pend_o, 0);
        check("R1 irq", irq_o, 0);
    endtask

    task automatic t_free_run();
        step_mode_i = 1'b0;
        pulse_start();
        check("R2 run after start", run_o, 1);
        for (int i = 0; i < 3; i++) begin
            pulse_done();
            check("R4 still running", run_o, 1);
        end
        check("R4 no step irq", step_irq_o, 0);
        pulse_start();
        check("R8 start while running", run_o, 1);
        settle();
    endtask

    task automatic t_step_restart();
        step_mode_i = 1'b1;
        pulse_start();
        check("R2 run", run_o, 1);
        pulse_done();
        check("R3 halted", run_o, 0);
        check("R3 step irq", step_irq_o, 1);
        check("R9 irq raised", irq_o, 1);
        pulse_start();
        check("R8 start ignored while pending", run_o, 0);
        do_read();
        check("R7 step cleared", step_irq_o, 0);
        check("R7 irq dropped", irq_o, 0);
        pulse_start();
        check("R8 restart after clear", run_o, 1);
        settle();
        step_mode_i = 1'b0;
    endtask

    task automatic t_src_halt();
        pulse_start();
        irq_src_i = 4'b0100; tick(); irq_src_i = '0;
        check("R5 halted", run_o, 0);
        check("R5 pend bit", src_pend_o, 4);
        settle();
    endtask

    task automatic t_both();
        step_mode_i = 1'b1;
        pulse_start();
        instr_done_i = 1'b1; irq_src_i = 4'b0001; tick();
        instr_done_i = 1'b0; irq_src_i = '0;
        check("R6 step bit", step_irq_o, 1);
        check("R6 src bit", src_pend_o, 1);
        check("R6 halted", run_o, 0);
        settle();
        step_mode_i = 1'b0;
    endtask

    task automatic t_read_vs_event();
        irq_src_i = 4'b1000; tick(); irq_src_i = '0;
        check("R5 latched while idle", src_pend_o, 8);
        stat_rd_i = 1'b1; irq_src_i = 4'b0010; tick();
        stat_rd_i = 1'b0; irq_src_i = '0;
        check("R7 new event kept old cleared", src_pend_o, 2);
        settle();
        check("R7 all clear", src_pend_o, 0);
    endtask

    task automatic t_mask();
        irq_src_i = 4'b0010; tick(); irq_src_i = '0;
        src_mask_i = 4'b1101; #1;
        check("R9 masked off", irq_o, 0);
        src_mask_i = 4'b0010; #1;
        check("R9 unmasked", irq_o, 1);
        src_mask_i = '1;
        settle();
        step_mode_i = 1'b1; pulse_start(); pulse_done();
        step_mask_i = 1'b0; #1;
        check("R9 step masked", irq_o, 0);
        step_mask_i = 1'b1; #1;
        check("R9 step unmasked", irq_o, 1);
        settle();
        step_mode_i = 1'b0;
    endtask

    task automatic t_mode_change();
        step_mode_i = 1'b0;
        pulse_start();
        step_mode_i = 1'b1;
        pulse_done();
        check("R10 old free mode governs", run_o, 1);
        pulse_done();
        check("R10 new step mode halts", run_o, 0);
        settle();
        step_mode_i = 1'b1;
        pulse_start();
        step_mode_i = 1'b0;
        pulse_done();
        check("R10 old step mode halts", run_o, 0);
        do_read();
        pulse_start();
        pulse_done();
        check("R10 free after restart", run_o, 1);
        settle();
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        t_reset();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_free_run();
        t_step_restart();
        t_src_halt();
        t_both();
        t_read_vs_event();
        t_mask();
        t_mode_change();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule